// File: doc/BRIEF.md
# Interlock and Operand Bypass Controller for a Five-Stage Pipeline

This block is the hazard control for an in-order integer pipeline with five stages. Each stage takes one cycle: fetch, decode, execute, memory and write-back. The decode stage presents its two source register numbers. The execute and memory pipeline registers present their destination number and a write flag, and the execute register also flags a load. From these the block decides two things. It decides whether the instruction in decode may advance or must wait, in which case fetch and the decode register are held and an empty slot enters execute. For instructions that advance, it decides where each ALU operand comes from in the next cycle. The choices are the register file value read in decode, the result held in the execute/memory register, or the result held in the memory/write-back register.

A static mode input selects one of two policies. With bypassing off, the block waits until the producer has reached write-back. The register file writes early in the cycle and reads late, so decode sees the new value at that point. With bypassing on, ALU results are steered straight back into execute. Only a load followed at once by a consumer still costs one cycle. The bypass selects are worked out in decode and registered, so they are valid during the cycle in which the consumer sits in execute. Unused source fields are expected as register 0.

Top module: `hzd_ctrl`

## Requirements
- R1: With bypassing off (`fwd_en`=0), `stall_front` is 1 while a nonzero source of decode equals the destination of a writing instruction in execute or in memory. A back-to-back ALU dependence therefore costs exactly two stall cycles.
- R2: A producer whose write flag is low causes no stall, and neither does a producer that has moved on to write-back.
- R3: `bubble_ex` is 1 in exactly the cycles in which `stall_front` is 1. In the cycle after a stall, both selects read 0, which is the select for the empty slot.
- R4: With bypassing on, a non-load producer in execute that matches a source causes no stall. In the next cycle that operand's select is 1, meaning the result from the execute/memory register.
- R5: With bypassing on, a producer in memory that matches a source (and no match in execute) gives select 2 in the next cycle, meaning the result from the memory/write-back register.
- R6: When both the execute and the memory producers match the same source, the select is 1, because the younger result wins.
- R7: A load in execute that matches a source stalls for one cycle even with bypassing on. When the load then sits in memory, the operand's select is 2.
- R8: Source register 0 never causes a stall and is never bypassed. Its select stays 0.
- R9: With bypassing off, both selects are always 0 (register file value).
- R10: Eight chained ALU operations give the same register results in both modes, with 14 stall cycles without bypassing and none with it. An ALU, load and consumer chain gives the same results in both modes, with 4 stalls versus 1.
- R11: After reset, with idle inputs, `stall_front`, `bubble_ex`, `sel_a` and `sel_b` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset of the select registers |
| fwd_en | input | 1 | Static mode: 1 enables bypassing, 0 uses the interlock only |
| id_src_a | input | REG_AW | First source register of the instruction in decode |
| id_src_b | input | REG_AW | Second source register of the instruction in decode |
| ex_dst | input | REG_AW | Destination held in the execute pipeline register |
| ex_wen | input | 1 | Execute-stage instruction writes a register |
| ex_load | input | 1 | Execute-stage instruction is a load |
| mem_dst | input | REG_AW | Destination held in the memory pipeline register |
| mem_wen | input | 1 | Memory-stage instruction writes a register |
| stall_front | output | 1 | Hold the PC and the decode register |
| bubble_ex | output | 1 | Load an empty slot into the execute register |
| sel_a | output | 2 | Operand A source in execute: 0 file, 1 EX/MEM, 2 MEM/WB |
| sel_b | output | 2 | Operand B source in execute: 0 file, 1 EX/MEM, 2 MEM/WB |

## Verification
The selects are registered, so a corrupted select state appears on `sel_a` or `sel_b` in the very next cycle. It then turns into a wrong ALU result that reaches the register file three cycles later. A wrong stall decision is visible at once on `stall_front`. It also shifts the stall total of a program run and can corrupt a consumer's operand, which shows up in the final register contents. The directed port-level cases expose decision errors within one or two cycles. The chained programs run in both modes expose any mismatch in the final architectural state.

// File: rtl/hzd_pkg.sv
package hzd_pkg;
   typedef enum logic [1:0] {
      BYP_RF    = 2'd0,
      BYP_EXMEM = 2'd1,
      BYP_MEMWB = 2'd2
   } byp_sel_e;
endpackage

// File: rtl/hzd_src_match.sv
module hzd_src_match #(
   parameter int REG_AW         = 5,
   parameter bit ZERO_HARDWIRED = 1'b1
) (
   input  logic [REG_AW-1:0] src,
   input  logic [REG_AW-1:0] ex_dst,
   input  logic              ex_wen,
   input  logic              ex_load,
   input  logic [REG_AW-1:0] mem_dst,
   input  logic              mem_wen,
   output logic              hit_ex_alu,
   output logic              hit_ex_load,
   output logic              hit_mem
);
   logic live;
   logic eq_ex;
   logic eq_mem;

   generate
      if (ZERO_HARDWIRED) begin : g_zero
         assign live = |src;
      end else begin : g_plain
         assign live = 1'b1;
      end
   endgenerate

   assign eq_ex       = live && ex_wen  && (ex_dst  == src);
   assign eq_mem      = live && mem_wen && (mem_dst == src);
   assign hit_ex_alu  = eq_ex && !ex_load;
   assign hit_ex_load = eq_ex &&  ex_load;
   assign hit_mem     = eq_mem;
endmodule

// File: rtl/hzd_src_ctl.sv
module hzd_src_ctl (
   input  logic               fwd_en,
   input  logic               hit_ex_alu,
   input  logic               hit_ex_load,
   input  logic               hit_mem,
   output logic               need_stall,
   output hzd_pkg::byp_sel_e  sel_nxt
);
   always_comb begin
      need_stall = 1'b0;
      sel_nxt    = hzd_pkg::BYP_RF;
      if (!fwd_en) begin
         need_stall = hit_ex_alu | hit_ex_load | hit_mem;
      end else if (hit_ex_load) begin
         need_stall = 1'b1;
      end else if (hit_ex_alu) begin
         sel_nxt = hzd_pkg::BYP_EXMEM;
      end else if (hit_mem) begin
         sel_nxt = hzd_pkg::BYP_MEMWB;
      end
   end
endmodule

// File: rtl/hzd_sel_reg.sv
module hzd_sel_reg (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               clr,
   input  hzd_pkg::byp_sel_e  d,
   output hzd_pkg::byp_sel_e  q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   q <= hzd_pkg::BYP_RF;
      else if (clr) q <= hzd_pkg::BYP_RF;
      else          q <= d;
   end
endmodule

// File: rtl/hzd_ctrl.sv
module hzd_ctrl #(
   parameter int REG_AW         = 5,
   parameter bit ZERO_HARDWIRED = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fwd_en,
   input  logic [REG_AW-1:0] id_src_a,
   input  logic [REG_AW-1:0] id_src_b,
   input  logic [REG_AW-1:0] ex_dst,
   input  logic              ex_wen,
   input  logic              ex_load,
   input  logic [REG_AW-1:0] mem_dst,
   input  logic              mem_wen,
   output logic              stall_front,
   output logic              bubble_ex,
   output logic [1:0]        sel_a,
   output logic [1:0]        sel_b
);
   localparam int N_SRC = 2;
   localparam int SEL_W = $bits(hzd_pkg::byp_sel_e);

   generate
      if (REG_AW < 1 || REG_AW > 8) begin : g_bad_aw
         $error("hzd_ctrl: REG_AW must lie in 1..8");
      end
      if (SEL_W != 2) begin : g_bad_sel
         $error("hzd_ctrl: select encoding must be two bits");
      end
   endgenerate

   logic [REG_AW-1:0]  src_v [N_SRC];
   logic [N_SRC-1:0]   need_stall;
   hzd_pkg::byp_sel_e  sel_d [N_SRC];
   hzd_pkg::byp_sel_e  sel_q [N_SRC];

   assign src_v[0] = id_src_a;
   assign src_v[1] = id_src_b;

   for (genvar i = 0; i < N_SRC; i++) begin : g_src
      logic h_alu, h_load, h_mem;

      hzd_src_match #(.REG_AW(REG_AW), .ZERO_HARDWIRED(ZERO_HARDWIRED)) i_match (
         .src         (src_v[i]),
         .ex_dst      (ex_dst),
         .ex_wen      (ex_wen),
         .ex_load     (ex_load),
         .mem_dst     (mem_dst),
         .mem_wen     (mem_wen),
         .hit_ex_alu  (h_alu),
         .hit_ex_load (h_load),
         .hit_mem     (h_mem)
      );

      hzd_src_ctl i_ctl (
         .fwd_en      (fwd_en),
         .hit_ex_alu  (h_alu),
         .hit_ex_load (h_load),
         .hit_mem     (h_mem),
         .need_stall  (need_stall[i]),
         .sel_nxt     (sel_d[i])
      );

      hzd_sel_reg i_reg (
         .clk   (clk),
         .rst_n (rst_n),
         .clr   (stall_front),
         .d     (sel_d[i]),
         .q     (sel_q[i])
      );
   end

   assign stall_front = |need_stall;
   assign bubble_ex   = stall_front;
   assign sel_a       = sel_q[0];
   assign sel_b       = sel_q[1];
endmodule

// File: rtl/hzd_ctrl_chk.sv
module hzd_ctrl_chk #(
   parameter int REG_AW         = 5,
   parameter bit ZERO_HARDWIRED = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              fwd_en,
   input logic [REG_AW-1:0] id_src_a,
   input logic [REG_AW-1:0] id_src_b,
   input logic [REG_AW-1:0] ex_dst,
   input logic              ex_wen,
   input logic              ex_load,
   input logic [REG_AW-1:0] mem_dst,
   input logic              mem_wen,
   input logic              stall_front,
   input logic              bubble_ex,
   input logic [1:0]        sel_a,
   input logic [1:0]        sel_b
);
   logic zh;
   assign zh = ZERO_HARDWIRED;

   AST_EX_INTERLOCK: assert property (@(posedge clk) disable iff (!rst_n)
      (!fwd_en && ex_wen && (!zh || ex_dst != '0) && ex_dst == id_src_a) |-> stall_front); // R1
   AST_MEM_INTERLOCK: assert property (@(posedge clk) disable iff (!rst_n)
      (!fwd_en && mem_wen && (!zh || mem_dst != '0) && mem_dst == id_src_b) |-> stall_front); // R1
   AST_BUBBLE_PAIRED: assert property (@(posedge clk) disable iff (!rst_n)
      stall_front |-> bubble_ex); // R3
   AST_BUBBLE_SEL_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      stall_front |=> (sel_a == 2'd0 && sel_b == 2'd0)); // R3
   AST_SEL_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_a != 2'd3 && sel_b != 2'd3)); // R4
   AST_YOUNGER_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (fwd_en && !stall_front && ex_wen && !ex_load && id_src_a != '0 && ex_dst == id_src_a)
      |=> sel_a == 2'd1); // R6
   AST_LOAD_USE: assert property (@(posedge clk) disable iff (!rst_n)
      (ex_wen && ex_load && ex_dst != '0 && (ex_dst == id_src_a || ex_dst == id_src_b))
      |-> stall_front); // R7
   AST_ZERO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (zh && id_src_a == '0 && id_src_b == '0) |-> !stall_front); // R8
   AST_INTERLOCK_FILE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      !fwd_en |=> (sel_a == 2'd0 && sel_b == 2'd0)); // R9
endmodule

bind hzd_ctrl hzd_ctrl_chk #(.REG_AW(REG_AW), .ZERO_HARDWIRED(ZERO_HARDWIRED)) i_chk (.*);

// File: tb/test_hzd_ctrl.sv
module test_hzd_ctrl;
   localparam int CLK_P = 10;
   localparam int AW    = 5;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic d_fwd = 1'b0;
   logic [AW-1:0] d_src_a = '0, d_src_b = '0, d_ex_dst = '0, d_mem_dst = '0;
   logic d_ex_wen = 1'b0, d_ex_load = 1'b0, d_mem_wen = 1'b0;
   logic stall_front, bubble_ex;
   logic [1:0] sel_a, sel_b;

   int n_chk = 0;
   int n_fail = 0;

   always #(CLK_P/2) clk = ~clk;

   hzd_ctrl #(.REG_AW(AW)) i_hzd_ctrl (
      .clk(clk), .rst_n(rst_n), .fwd_en(d_fwd),
      .id_src_a(d_src_a), .id_src_b(d_src_b),
      .ex_dst(d_ex_dst), .ex_wen(d_ex_wen), .ex_load(d_ex_load),
      .mem_dst(d_mem_dst), .mem_wen(d_mem_wen),
      .stall_front(stall_front), .bubble_ex(bubble_ex),
      .sel_a(sel_a), .sel_b(sel_b)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: got %0d, expected %0d", req, act, exp);
      end
   endtask

   task automatic idle_inputs();
      d_src_a = '0; d_src_b = '0; d_ex_dst = '0; d_mem_dst = '0;
      d_ex_wen = 0; d_ex_load = 0; d_mem_wen = 0;
   endtask

   task automatic do_reset(input logic mode);
      @(negedge clk);
      rst_n = 0; idle_inputs(); d_fwd = mode;
      repeat (2) @(negedge clk);
      rst_n = 1;
   endtask

   // ---------------- directed port-level scenarios ----------------
   task automatic t_reset();
      do_reset(1'b1);
      #1;
      chk("R11 stall after reset", stall_front, 0);
      chk("R11 bubble after reset", bubble_ex, 0);
      chk("R11 sel_a after reset", sel_a, 0);
      chk("R11 sel_b after reset", sel_b, 0);
   endtask

   task automatic t_interlock();
      do_reset(1'b0);
      @(negedge clk);
      d_src_a = 3; d_ex_dst = 3; d_ex_wen = 1;
      #1;
      chk("R1 stall on EX match", stall_front, 1);
      chk("R3 bubble with stall", bubble_ex, 1);
      @(negedge clk);
      chk("R3 sel_a after stall", sel_a, 0);
      idle_inputs(); d_src_b = 4; d_mem_dst = 4; d_mem_wen = 1; d_ex_dst = 9; d_ex_wen = 1;
      #1;
      chk("R1 stall on MEM match", stall_front, 1);
      @(negedge clk);
      idle_inputs(); d_src_a = 6; d_ex_dst = 6; d_ex_wen = 0;
      #1;
      chk("R2 no stall when write flag low", stall_front, 0);
      chk("R3 no bubble without stall", bubble_ex, 0);
      @(negedge clk);
      chk("R9 sel_a file in interlock mode", sel_a, 0);
      chk("R9 sel_b file in interlock mode", sel_b, 0);
   endtask

   task automatic t_bypass();
      do_reset(1'b1);
      @(negedge clk);
      d_src_a = 3; d_ex_dst = 3; d_ex_wen = 1;
      #1;
      chk("R4 no stall on ALU EX match", stall_front, 0);
      @(negedge clk);
      chk("R4 sel_a from EX/MEM", sel_a, 1);
      chk("R4 sel_b untouched", sel_b, 0);
      idle_inputs(); d_src_b = 6; d_mem_dst = 6; d_mem_wen = 1;
      #1;
      chk("R5 no stall on MEM match", stall_front, 0);
      @(negedge clk);
      chk("R5 sel_b from MEM/WB", sel_b, 2);
      idle_inputs(); d_src_a = 5; d_ex_dst = 5; d_ex_wen = 1; d_mem_dst = 5; d_mem_wen = 1;
      @(negedge clk);
      chk("R6 younger result wins", sel_a, 1);
      idle_inputs(); d_src_b = 2; d_ex_dst = 9; d_ex_wen = 1;
      @(negedge clk);
      chk("R4 no select on mismatch", sel_b, 0);
   endtask

   task automatic t_load_use();
      do_reset(1'b1);
      @(negedge clk);
      d_src_b = 7; d_ex_dst = 7; d_ex_wen = 1; d_ex_load = 1;
      #1;
      chk("R7 load-use stall with bypass", stall_front, 1);
      @(negedge clk);
      chk("R7 bubble select", sel_b, 0);
      idle_inputs(); d_src_b = 7; d_mem_dst = 7; d_mem_wen = 1;
      #1;
      chk("R7 single stall cycle", stall_front, 0);
      @(negedge clk);
      chk("R7 loaded value from MEM/WB", sel_b, 2);
   endtask

   task automatic t_zero(input logic mode);
      do_reset(mode);
      @(negedge clk);
      d_src_a = 0; d_src_b = 0; d_ex_dst = 0; d_ex_wen = 1; d_ex_load = 1;
      d_mem_dst = 0; d_mem_wen = 1;
      #1;
      chk("R8 register 0 never stalls", stall_front, 0);
      @(negedge clk);
      chk("R8 register 0 sel_a", sel_a, 0);
      chk("R8 register 0 sel_b", sel_b, 0);
   endtask

   // ---------------- small reference pipeline ----------------
   typedef struct packed {
      logic        ld;
      logic [4:0]  rd, rs1, rs2;
      logic [15:0] imm;
   } ins_t;

   ins_t prog [16];
   int   rf   [32];

   task automatic run_prog(input logic mode, input int cycles, output int stalls);
      ins_t fd, ie, n_fd, n_ie;
      logic [31:0] ie_va, ie_vb, em_val, mw_val, n_ie_va, n_ie_vb, n_em_val, n_mw_val;
      logic [4:0]  em_rd, mw_rd, n_em_rd, n_mw_rd;
      logic        em_wen, mw_wen, em_ld, n_em_wen, n_mw_wen, n_em_ld;
      logic [31:0] opa, opb;
      int pc, n_pc;
      stalls = 0;
      for (int i = 0; i < 32; i++) rf[i] = 0;
      do_reset(mode);
      n_fd = '0; n_ie = '0; n_ie_va = 0; n_ie_vb = 0;
      n_em_val = 0; n_mw_val = 0; n_em_rd = 0; n_mw_rd = 0;
      n_em_wen = 0; n_mw_wen = 0; n_em_ld = 0; n_pc = 0;
      for (int c = 0; c < cycles; c++) begin
         @(negedge clk);
         fd = n_fd; ie = n_ie; ie_va = n_ie_va; ie_vb = n_ie_vb;
         em_val = n_em_val; em_rd = n_em_rd; em_wen = n_em_wen; em_ld = n_em_ld;
         mw_val = n_mw_val; mw_rd = n_mw_rd; mw_wen = n_mw_wen; pc = n_pc;
         d_src_a = fd.rs1; d_src_b = fd.rs2;
         d_ex_dst = ie.rd; d_ex_wen = (ie.rd != 0); d_ex_load = ie.ld;
         d_mem_dst = em_rd; d_mem_wen = em_wen;
         #1;
         if (stall_front) stalls++;
         if (mw_wen) rf[mw_rd] = int'(mw_val);
         opa = (sel_a == 2'd1) ? em_val : (sel_a == 2'd2) ? mw_val : ie_va;
         opb = (sel_b == 2'd1) ? em_val : (sel_b == 2'd2) ? mw_val : ie_vb;
         n_mw_rd = em_rd; n_mw_wen = em_wen;
         n_mw_val = em_ld ? em_val * 3 + 1 : em_val;
         n_em_rd = ie.rd; n_em_wen = (ie.rd != 0); n_em_ld = ie.ld;
         n_em_val = ie.ld ? opa + 32'(ie.imm) : opa + opb + 32'(ie.imm);
         if (stall_front) begin
            n_ie = '0; n_ie_va = 0; n_ie_vb = 0;
            n_fd = fd; n_pc = pc;
         end else begin
            n_ie = fd; n_ie_va = 32'(rf[fd.rs1]); n_ie_vb = 32'(rf[fd.rs2]);
            n_fd = (pc < 16) ? prog[pc] : '0;
            n_pc = pc + 1;
         end
      end
   endtask

   task automatic load_chain();
      for (int i = 0; i < 16; i++) prog[i] = '0;
      prog[0] = '{ld: 0, rd: 1, rs1: 0, rs2: 0, imm: 16'd7};
      for (int k = 1; k < 8; k++)
         prog[k] = '{ld: 0, rd: 5'(k + 1), rs1: 5'(k), rs2: 5'(k), imm: 16'd1};
   endtask

   task automatic load_ldprog();
      for (int i = 0; i < 16; i++) prog[i] = '0;
      prog[0] = '{ld: 0, rd: 1, rs1: 0, rs2: 0, imm: 16'd20};
      prog[1] = '{ld: 1, rd: 2, rs1: 1, rs2: 0, imm: 16'd0};
      prog[2] = '{ld: 0, rd: 3, rs1: 2, rs2: 2, imm: 16'd0};
   endtask

   task automatic t_chain();
      int st;
      int exp_v;
      for (int m = 0; m < 2; m++) begin
         load_chain();
         run_prog(logic'(m), 45, st);
         chk(m ? "R10 chain stalls with bypass" : "R10 chain stalls interlock", st, m ? 0 : 14);
         exp_v = 7;
         for (int k = 1; k <= 8; k++) begin
            chk("R10 chain register value", rf[k], exp_v);
            exp_v = exp_v * 2 + 1;
         end
      end
   endtask

   task automatic t_ldprog();
      int st;
      for (int m = 0; m < 2; m++) begin
         load_ldprog();
         run_prog(logic'(m), 30, st);
         chk(m ? "R7 R10 load program stalls bypass" : "R10 load program stalls interlock", st, m ? 1 : 4);
         chk("R10 loaded register", rf[2], 61);
         chk("R10 load consumer result", rf[3], 122);
      end
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   initial begin
      #(CLK_P * 100000);
      n_fail++;
      $display("FAIL watchdog: got %0d, expected %0d", 0, 1);
      summary();
      $finish;
   end

   initial begin
      t_reset();
      t_interlock();
      t_bypass();
      t_load_use();
      t_zero(1'b0);
      t_zero(1'b1);
      t_chain();
      t_ldprog();
      summary();
      $finish;
   end
endmodule